// File: doc/BRIEF.md
# Priority-Grouped Interrupt Pending Tracker

This block watches a vector of level-sensitive interrupt lines and groups them by a per-line priority level. Each line carries a 4-bit priority held in a small register table that software-side logic loads through a simple write port. The block keeps one pending flag per line and a 16-bit mask with one bit per priority level. A mask bit is set while at least one pending line has that priority. A single request to the processor is raised whenever the mask is non-zero.

Lines are numbered from a base of 16. Bit k of the level input is line number 16+k, and the write port addresses lines by that number. Level changes are found by comparing each input with its value on the previous clock. Any number of lines may change in the same cycle. All outputs are registered and follow an input change or a priority write by one clock edge.

Top module: `irq_prio_tracker`

## Requirements
- R1: A synchronous active-high reset clears every pending flag, the priority mask and the request, sets every line's priority to 0, and forgets the previous input levels. A line that is high when reset is released is therefore seen as newly asserted on the next edge.
- R2: Input bit k is line number LINE_BASE+k, with LINE_BASE defaulting to 16. A priority write whose `cfg_line` lies below LINE_BASE, or at or above LINE_BASE+NUM_LINES, changes nothing.
- R3: On the first clock edge at which a line is sampled high after being low, its `line_pend` bit becomes 1 and `prio_pend` bit number P becomes 1, where P is that line's priority. The mask value is 1 shifted left by P.
- R4: On the first clock edge at which a line is sampled low after being high, its `line_pend` bit becomes 0.
- R5: When a line falls, the mask bit of its priority stays set if another line with the same priority is still pending. Otherwise it clears on that edge.
- R6: `cpu_irq` is 1 exactly in the cycles in which `prio_pend` is non-zero.
- R7: Rising and falling lines in the same cycle are all processed on the same edge.
- R8: A write of `cfg_prio` to a line while that line is pending moves its contribution from the old mask bit to the new one on the write's clock edge. The old bit stays set only if another pending line shares it.
- R9: With inputs unchanged and no write, all outputs hold their values.
- R10: Every priority value from 0 to 15 selects its own mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lvl | input | NUM_LINES | Interrupt line levels; bit k is line LINE_BASE+k |
| cfg_we | input | 1 | Priority write strobe |
| cfg_line | input | NUM_W | Line number addressed by the write |
| cfg_prio | input | 4 | Priority value written |
| line_pend | output | NUM_LINES | Per-line pending flags |
| prio_pend | output | 16 | Per-priority pending mask |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
The properties assume that `irq_lvl` is synchronous to `clk` and changes only between edges. They also assume that the write fields are stable whenever `cfg_we` is high. The bench drives every input on the falling edge and samples on the next falling edge, so each change meets exactly one rising edge. Write addresses cover in-range lines, the exact end points of the line range, and numbers that would alias onto a real line if truncated. Together these cover the ignored-write cases.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  localparam int PRIO_LEVELS = 16;
  localparam int PRIO_W      = $clog2(PRIO_LEVELS);

  typedef logic [PRIO_W-1:0]      prio_t;
  typedef logic [PRIO_LEVELS-1:0] pmask_t;
endpackage

// File: rtl/irqt_level_track.sv
// Edge detection against the previous sample and per-line pending state.
module irqt_level_track #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lvl_i,
  output logic [NUM_LINES-1:0] pend_next_o,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] lvl_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] fall;

  always_comb begin
    rise        = lvl_i & ~lvl_q;
    fall        = ~lvl_i & lvl_q;
    pend_next_o = (pend_q | rise) & ~fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= lvl_i;
      pend_q <= pend_next_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqt_prio_table.sv
// Per-line priority registers with range-checked write decode.
module irqt_prio_table
  import irqt_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int LINE_BASE = 16,
  parameter int NUM_W     = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [NUM_W-1:0]      line_i,
  input  prio_t                 prio_i,
  output prio_t [NUM_LINES-1:0] prio_next_o
);
  localparam int LAST_LINE = LINE_BASE + NUM_LINES - 1;

  prio_t [NUM_LINES-1:0] prio_q;
  logic                  in_range;
  logic [NUM_W-1:0]      idx;

  always_comb begin
    in_range = (32'(line_i) >= LINE_BASE) && (32'(line_i) <= LAST_LINE);
    idx      = line_i - NUM_W'(LINE_BASE);
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic sel;
    assign sel            = we_i && in_range && (idx == NUM_W'(i));
    assign prio_next_o[i] = sel ? prio_i : prio_q[i];

    always_ff @(posedge clk) begin
      if (rst) prio_q[i] <= '0;
      else     prio_q[i] <= prio_next_o[i];
    end
  end
endmodule

// File: rtl/irqt_prio_reduce.sv
// Folds pending lines into one bit per priority level.
module irqt_prio_reduce
  import irqt_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0] pend_i,
  input  prio_t [NUM_LINES-1:0] prio_i,
  output pmask_t                mask_o
);
  for (genvar p = 0; p < PRIO_LEVELS; p++) begin : g_level
    logic [NUM_LINES-1:0] member;
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_member
      assign member[i] = pend_i[i] && (prio_i[i] == prio_t'(p));
    end
    assign mask_o[p] = |member;
  end
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
  import irqt_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int LINE_BASE = 16,
  parameter int NUM_W     = $clog2(LINE_BASE + NUM_LINES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_LINES-1:0]   irq_lvl,
  input  logic                   cfg_we,
  input  logic [NUM_W-1:0]       cfg_line,
  input  logic [PRIO_W-1:0]      cfg_prio,
  output logic [NUM_LINES-1:0]   line_pend,
  output logic [PRIO_LEVELS-1:0] prio_pend,
  output logic                   cpu_irq
);
  logic [NUM_LINES-1:0]  pend_next;
  prio_t [NUM_LINES-1:0] prio_next;
  pmask_t                mask_next;
  pmask_t                mask_q;
  logic                  irq_q;

  irqt_level_track #(.NUM_LINES(NUM_LINES)) u_track (
    .clk         (clk),
    .rst         (rst),
    .lvl_i       (irq_lvl),
    .pend_next_o (pend_next),
    .pend_o      (line_pend)
  );

  irqt_prio_table #(
    .NUM_LINES (NUM_LINES),
    .LINE_BASE (LINE_BASE),
    .NUM_W     (NUM_W)
  ) u_table (
    .clk         (clk),
    .rst         (rst),
    .we_i        (cfg_we),
    .line_i      (cfg_line),
    .prio_i      (cfg_prio),
    .prio_next_o (prio_next)
  );

  irqt_prio_reduce #(.NUM_LINES(NUM_LINES)) u_reduce (
    .pend_i (pend_next),
    .prio_i (prio_next),
    .mask_o (mask_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_next;
      irq_q  <= |mask_next;
    end
  end

  assign prio_pend = mask_q;
  assign cpu_irq   = irq_q;
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker #(
  parameter int NUM_LINES = 32,
  parameter int NUM_PRIO  = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_lvl,
  input logic                 cfg_we,
  input logic [NUM_LINES-1:0] line_pend,
  input logic [NUM_PRIO-1:0]  prio_pend,
  input logic                 cpu_irq
);
  // R1: reset empties all state on the following edge
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (line_pend == '0 && prio_pend == '0 && !cpu_irq));

  // R3: newly high lines become pending
  a_r3_rise_sets: assert property (@(posedge clk) disable iff (rst)
    ((irq_lvl & ~line_pend) != '0) |=>
      ((line_pend & $past(irq_lvl & ~line_pend)) == $past(irq_lvl & ~line_pend)));

  // R4: low pending lines drop their flag
  a_r4_fall_clears: assert property (@(posedge clk) disable iff (rst)
    ((~irq_lvl & line_pend) != '0) |=>
      ((line_pend & $past(~irq_lvl & line_pend)) == '0));

  // R5: a set mask bit always has a pending line behind it
  a_r5_mask_backed: assert property (@(posedge clk) disable iff (rst)
    $countones(prio_pend) <= $countones(line_pend));

  // R5: pending lines are always represented in the mask
  a_r5_pend_in_mask: assert property (@(posedge clk) disable iff (rst)
    (line_pend != '0) |-> (prio_pend != '0));

  // R6: request mirrors a non-empty mask
  a_r6_req_matches: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (prio_pend != '0));

  // R9: no change in, no change out
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_lvl == line_pend && !cfg_we) |=>
      ($stable(prio_pend) && $stable(line_pend) && $stable(cpu_irq)));
endmodule

bind irq_prio_tracker irqt_checker #(
  .NUM_LINES (NUM_LINES),
  .NUM_PRIO  (irqt_pkg::PRIO_LEVELS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_lvl   (irq_lvl),
  .cfg_we    (cfg_we),
  .line_pend (line_pend),
  .prio_pend (prio_pend),
  .cpu_irq   (cpu_irq)
);

// File: tb/sim_irq_prio_tracker.sv
`timescale 1ns/1ps
module sim_irq_prio_tracker;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] irq_lvl;
  logic        cfg_we;
  logic [5:0]  cfg_line;
  logic [3:0]  cfg_prio;
  logic [31:0] line_pend;
  logic [15:0] prio_pend;
  logic        cpu_irq;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  irq_prio_tracker u0 (
    .clk (clk), .rst (rst), .irq_lvl (irq_lvl), .cfg_we (cfg_we),
    .cfg_line (cfg_line), .cfg_prio (cfg_prio), .line_pend (line_pend),
    .prio_pend (prio_pend), .cpu_irq (cpu_irq)
  );

  // {we, line, prio, levels, expected pend, expected mask, expected irq}
  localparam int NV = 13;
  localparam logic [91:0] VEC [NV] = '{
    {1'b1, 6'd16, 4'd3,  32'h0000_0000, 32'h0000_0000, 16'h0000, 1'b0},
    {1'b1, 6'd17, 4'd3,  32'h0000_0001, 32'h0000_0001, 16'h0008, 1'b1},
    {1'b1, 6'd20, 4'd9,  32'h0000_0003, 32'h0000_0003, 16'h0008, 1'b1},
    {1'b0, 6'd0,  4'd0,  32'h0000_0002, 32'h0000_0002, 16'h0008, 1'b1},
    {1'b0, 6'd0,  4'd0,  32'h0000_0000, 32'h0000_0000, 16'h0000, 1'b0},
    {1'b0, 6'd0,  4'd0,  32'h0000_0013, 32'h0000_0013, 16'h0208, 1'b1},
    {1'b1, 6'd20, 4'd15, 32'h0000_0013, 32'h0000_0013, 16'h8008, 1'b1},
    {1'b1, 6'd16, 4'd0,  32'h0000_0013, 32'h0000_0013, 16'h8009, 1'b1},
    {1'b0, 6'd0,  4'd0,  32'h0000_0003, 32'h0000_0003, 16'h0009, 1'b1},
    {1'b1, 6'd17, 4'd0,  32'h0000_0003, 32'h0000_0003, 16'h0001, 1'b1},
    {1'b0, 6'd0,  4'd0,  32'h8000_0000, 32'h8000_0000, 16'h0001, 1'b1},
    {1'b1, 6'd47, 4'd12, 32'h8000_0000, 32'h8000_0000, 16'h1000, 1'b1},
    {1'b0, 6'd0,  4'd0,  32'h0000_0000, 32'h0000_0000, 16'h0000, 1'b0}
  };

  function automatic string vec_req(int k);
    case (k)
      1, 2:    return "R3";
      3:       return "R5";
      4:       return "R4";
      5:       return "R7";
      6, 7, 9: return "R8";
      8:       return "R5";
      10:      return "R7";
      11:      return "R2";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] ep,
                         input logic [15:0] em, input logic ei);
    chk(req, "line_pend", line_pend, ep);
    chk(req, "prio_pend", {16'h0, prio_pend}, {16'h0, em});
    chk(req, "cpu_irq", {31'h0, cpu_irq}, {31'h0, ei});
  endtask

  // Called at a falling edge; returns one falling edge later.
  task automatic apply(input logic we, input logic [5:0] ln,
                       input logic [3:0] pr, input logic [31:0] lv);
    cfg_we   = we;
    cfg_line = ln;
    cfg_prio = pr;
    irq_lvl  = lv;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_lvl = '0; cfg_we = 1'b0; cfg_line = '0; cfg_prio = '0;
    repeat (3) @(negedge clk);
    chk_all("R1", 32'h0, 16'h0, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][91], VEC[k][90:85], VEC[k][84:81], VEC[k][80:49]);
      chk_all(vec_req(k), VEC[k][48:17], VEC[k][16:1], VEC[k][0]);
    end

    // R1: reset in the middle of activity, priorities return to 0
    apply(1'b0, 6'd0, 4'd0, 32'h5);
    chk_all("R3", 32'h5, 16'h0001, 1'b1);
    apply(1'b1, 6'd18, 4'd6, 32'h5);
    chk_all("R8", 32'h5, 16'h0041, 1'b1);
    cfg_we = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk_all("R1", 32'h0, 16'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1", 32'h5, 16'h0001, 1'b1);

    // R2: out-of-range line numbers are ignored
    apply(1'b1, 6'd48, 4'd7, 32'h5);
    chk_all("R2", 32'h5, 16'h0001, 1'b1);
    apply(1'b1, 6'd15, 4'd7, 32'h5);
    chk_all("R2", 32'h5, 16'h0001, 1'b1);
    apply(1'b1, 6'd0, 4'd9, 32'h5);
    chk_all("R2", 32'h5, 16'h0001, 1'b1);
    apply(1'b1, 6'd18, 4'd7, 32'h5);
    chk_all("R2", 32'h5, 16'h0081, 1'b1);

    // R10: every priority value selects its own bit
    apply(1'b0, 6'd0, 4'd0, 32'h1);
    chk_all("R5", 32'h1, 16'h0001, 1'b1);
    for (int p = 0; p < 16; p++) begin
      apply(1'b1, 6'd16, 4'(p), 32'h1);
      chk_all("R10", 32'h1, 16'(1 << p), 1'b1);
    end

    // R9: hold with no change
    for (int c = 0; c < 5; c++) begin
      apply(1'b0, 6'd0, 4'd0, 32'h1);
      chk_all("R9", 32'h1, 16'h8000, 1'b1);
    end

    apply(1'b0, 6'd0, 4'd0, 32'h0);
    chk_all("R6", 32'h0, 16'h0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule